// File: doc/BRIEF.md
# Monochrome PAL Composite Video Generator

This block produces a progressive (non-interlaced) monochrome frame with PAL-style timing from a 24 MHz clock. It drives two digital levels, a composite sync level and a one-bit picture level, which an external resistor network mixes into a composite video signal. During the visible part of each picture line it reads bytes from a byte-wide frame buffer through a synchronous read port and sends their bits out one pixel at a time.

A frame is a fixed sequence of half-line and full-line slots. The vertical interval uses wide-pulse half-lines and narrow-pulse half-lines. The picture lines each carry a horizontal sync pulse, a back porch and an active window of 416 pixels. The frame buffer address starts at a base value on every frame and advances by one per byte without restarting between lines. As a result, each picture line shows the next 52-byte row.

Top module: `pal_mono_video`

## Requirements
- R1: A picture line lasts 1536 clocks. `csync_o` is 0 for the first 96 clocks of the line and 1 for the remaining 1440 clocks.
- R2: A wide-pulse half-line lasts 768 clocks. `csync_o` is 0 for the first 720 clocks and 1 for the last 48 clocks.
- R3: A narrow-pulse half-line lasts 768 clocks. `csync_o` is 0 for the first 48 clocks and 1 for the last 720 clocks.
- R4: A frame contains, in this order, 5 wide-pulse half-lines, 5 narrow-pulse half-lines, `N_LINES` picture lines (default 304) and 6 narrow-pulse half-lines. The sequence then repeats without a gap, so each frame has 16 + `N_LINES` falling edges of `csync_o`.
- R5: `video_o` is 0 everywhere except the active window. The active window covers clocks 288 to 1535 of a picture line. Outside it, `video_o` is 0 during every sync pulse, the back porch and all vertical-interval half-lines.
- R6: The active window carries 52 bytes back to back, with no gap. Each byte gives 8 pixels, least-significant bit first, and each pixel is held for 3 clocks. Bit n of byte k is shown in window clocks 24k+3n to 24k+3n+2.
- R7: `fb_rd_en` is high for exactly one clock per byte. That clock is 2 clocks before the byte's first pixel. The read data is taken from `fb_rd_data` on the clock after the request. The request address is `BASE_ADDR` plus the number of bytes already read in the current frame, so picture line L, byte k reads `BASE_ADDR + 52*L + k`.
- R8: `frame_start` is a one-clock pulse, high in the first clock of the first wide-pulse half-line of every frame.
- R9: `rst_n` is a synchronous, active-low reset. From the clock after it is sampled low, `csync_o` is 1 and both `video_o` and `frame_start` are 0. On the first edge with `rst_n` high the block arms itself. The frame then begins in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel timebase clock (24 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_rd_en | output | 1 | Frame buffer read request, one clock per byte |
| fb_rd_addr | output | ADDR_W | Frame buffer byte address for the request |
| fb_rd_data | input | DATA_W | Frame buffer byte, valid the clock after the request |
| csync_o | output | 1 | Composite sync level (0 = sync tip) |
| video_o | output | 1 | Monochrome picture level |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The embedded properties assume three things about the surroundings. The frame buffer returns the requested byte on exactly the next clock. Reset is held low for at least two clocks. `rst_n` changes only away from the rising edge. The bench meets all three: its frame-buffer model answers every request with a non-blocking update on the edge that samples it, it holds reset for four clocks, and it drives `rst_n` only on falling edges. The bench uses a shortened picture-line count so that full frames fit in the run. It applies a second reset mid-picture to show that timing and addressing restart from the frame base.

// File: rtl/vid_pkg.sv
// Shared types for the monochrome composite video generator.
// Assumes nothing beyond the four-slot frame ordering below.
package vid_pkg;

    // Slot groups of one frame, in the order they are sent.
    typedef enum logic [1:0] {
        PH_LONG = 2'd0,   // wide-pulse half-lines
        PH_PRE  = 2'd1,   // narrow-pulse half-lines before the picture
        PH_PIC  = 2'd2,   // picture lines
        PH_POST = 2'd3    // narrow-pulse half-lines after the picture
    } phase_t;

    // Returns the group that follows p; the last group wraps to the first.
    function automatic phase_t phase_after(phase_t p);
        case (p)
            PH_LONG: phase_after = PH_PRE;
            PH_PRE:  phase_after = PH_PIC;
            PH_PIC:  phase_after = PH_POST;
            default: phase_after = PH_LONG;
        endcase
    endfunction

endpackage

// File: rtl/vid_timing.sv
// Frame timebase: walks the half-line / line slots of a frame and decodes
// the sync level, the active window, the first-fetch strobe and the frame
// start pulse. Assumes ACT_START >= 2 and that a line is twice a half-line.
module vid_timing
    import vid_pkg::*;
#(
    parameter int HSYNC_CLKS  = 96,
    parameter int PORCH_CLKS  = 192,
    parameter int ACTIVE_CLKS = 1248,
    parameter int EQ_CLKS     = 48,
    parameter int N_LONG      = 5,
    parameter int N_PRE       = 5,
    parameter int N_LINES     = 304,
    parameter int N_POST      = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic csync,
    output logic act,
    output logic fetch_go,
    output logic frame_start
);
    localparam int LINE_CLKS = HSYNC_CLKS + PORCH_CLKS + ACTIVE_CLKS;
    localparam int HALF_CLKS = LINE_CLKS / 2;
    localparam int LONG_LOW  = HALF_CLKS - EQ_CLKS;
    localparam int ACT_START = HSYNC_CLKS + PORCH_CLKS;
    localparam int LEAD      = 2;
    localparam int POS_W     = $clog2(LINE_CLKS);
    localparam int MAX_A     = (N_LONG > N_PRE) ? N_LONG : N_PRE;
    localparam int MAX_B     = (N_LINES > N_POST) ? N_LINES : N_POST;
    localparam int MAX_N     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int IDX_W     = $clog2(MAX_N + 1);

    localparam logic [POS_W-1:0] LINE_LAST = POS_W'(LINE_CLKS - 1);
    localparam logic [POS_W-1:0] HALF_LAST = POS_W'(HALF_CLKS - 1);
    localparam logic [POS_W-1:0] LOW_LONG  = POS_W'(LONG_LOW);
    localparam logic [POS_W-1:0] LOW_EQ    = POS_W'(EQ_CLKS);
    localparam logic [POS_W-1:0] LOW_HS    = POS_W'(HSYNC_CLKS);
    localparam logic [POS_W-1:0] WIN_START = POS_W'(ACT_START);
    localparam logic [POS_W-1:0] GO_POS    = POS_W'(ACT_START - LEAD);

    logic             run;
    phase_t           phase;
    logic [IDX_W-1:0] idx;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] seg_last;
    logic [IDX_W-1:0] idx_last;
    logic [POS_W-1:0] low_len;

    // Slot length, slot count and sync pulse width of the current group.
    always_comb begin
        seg_last = (phase == PH_PIC) ? LINE_LAST : HALF_LAST;
        case (phase)
            PH_LONG: begin idx_last = IDX_W'(N_LONG - 1);  low_len = LOW_LONG; end
            PH_PRE:  begin idx_last = IDX_W'(N_PRE - 1);   low_len = LOW_EQ;   end
            PH_PIC:  begin idx_last = IDX_W'(N_LINES - 1); low_len = LOW_HS;   end
            default: begin idx_last = IDX_W'(N_POST - 1);  low_len = LOW_EQ;   end
        endcase
    end

    // Position, slot index and group counters; held at frame origin until armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            phase <= PH_LONG;
            idx   <= '0;
            pos   <= '0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (pos == seg_last) begin
            pos <= '0;
            if (idx == idx_last) begin
                idx   <= '0;
                phase <= phase_after(phase);
            end else begin
                idx <= idx + 1'b1;
            end
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Output decode from the counters.
    assign csync       = !(run && (pos < low_len));
    assign act         = run && (phase == PH_PIC) && (pos >= WIN_START);
    assign fetch_go    = run && (phase == PH_PIC) && (pos == GO_POS);
    assign frame_start = run && (phase == PH_LONG) && (idx == '0) && (pos == '0);

    AST_PHASE_SEQ: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && phase != $past(phase)) |-> phase == phase_after($past(phase))); // R4
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) idx <= idx_last); // R4

endmodule

// File: rtl/vid_fetch.sv
// Frame buffer read sequencer: issues one read per byte, the first two
// clocks before the active window and then one every byte period, with an
// address that restarts at BASE_ADDR per frame and runs on across lines.
// Assumes fetch_go and frame_start are never high together.
module vid_fetch #(
    parameter int                BYTES_PER_LINE = 52,
    parameter int                BYTE_CLKS      = 24,
    parameter int                ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              fetch_go,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int SLOT_W = $clog2(BYTE_CLKS);
    localparam int NB_W   = $clog2(BYTES_PER_LINE + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BYTE_CLKS - 1);
    localparam logic [NB_W-1:0]   NB_LAST   = NB_W'(BYTES_PER_LINE - 1);

    logic [SLOT_W-1:0] slot;
    logic [NB_W-1:0]   nbyte;

    // A request on the line's first strobe, then whenever a byte period elapses.
    assign rd_en = fetch_go || ((nbyte != '0) && (slot == '0));

    // Address, byte-period and per-line byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= BASE_ADDR;
            slot    <= '0;
            nbyte   <= '0;
        end else begin
            if (frame_start)
                rd_addr <= BASE_ADDR;
            else if (rd_en)
                rd_addr <= rd_addr + 1'b1;
            if (rd_en) begin
                slot  <= SLOT_W'(1);
                nbyte <= (nbyte == NB_LAST) ? '0 : nbyte + 1'b1;
            end else if (nbyte != '0) begin
                slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
            end
        end
    end

    AST_RD_SPACED:     assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R7
    AST_BASE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> (rd_addr == BASE_ADDR)); // R7

endmodule

// File: rtl/vid_shifter.sv
// Pixel serialiser: captures the frame buffer byte one clock after each
// request and shifts it out LSB first, PIX_CLKS clocks per pixel.
// Assumes the read port answers exactly one clock after the request.
module vid_shifter #(
    parameter int DATA_W   = 8,
    parameter int PIX_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              act,
    output logic              video
);
    localparam int DIV_W = $clog2(PIX_CLKS + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PIX_CLKS - 1);

    logic              req_d;
    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  div;

    // Marks the clock in which requested data is present on rd_data.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req;
    end

    // Byte capture has priority over the per-pixel right shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            div   <= '0;
        end else if (req_d) begin
            shreg <= rd_data;
            div   <= '0;
        end else if (div == DIV_LAST) begin
            shreg <= shreg >> 1;
            div   <= '0;
        end else begin
            div <= div + 1'b1;
        end
    end

    assign video = act && shreg[0];

    AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) (req_d && act) |-> (div == DIV_LAST)); // R6

endmodule

// File: rtl/pal_mono_video.sv
// Monochrome progressive composite video generator top. Ties the frame
// timebase, the read sequencer and the pixel serialiser together. Assumes a
// synchronous frame buffer with one clock of read latency outside the block.
module pal_mono_video #(
    parameter int                DATA_W         = 8,
    parameter int                PIX_CLKS       = 3,
    parameter int                BYTES_PER_LINE = 52,
    parameter int                HSYNC_CLKS     = 96,
    parameter int                PORCH_CLKS     = 192,
    parameter int                EQ_CLKS        = 48,
    parameter int                N_LONG         = 5,
    parameter int                N_PRE          = 5,
    parameter int                N_LINES        = 304,
    parameter int                N_POST         = 6,
    parameter int                ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    input  logic [DATA_W-1:0] fb_rd_data,
    output logic              csync_o,
    output logic              video_o,
    output logic              frame_start
);
    localparam int BYTE_CLKS   = DATA_W * PIX_CLKS;
    localparam int ACTIVE_CLKS = BYTES_PER_LINE * BYTE_CLKS;

    logic act;
    logic fetch_go;

    vid_timing #(
        .HSYNC_CLKS (HSYNC_CLKS),
        .PORCH_CLKS (PORCH_CLKS),
        .ACTIVE_CLKS(ACTIVE_CLKS),
        .EQ_CLKS    (EQ_CLKS),
        .N_LONG     (N_LONG),
        .N_PRE      (N_PRE),
        .N_LINES    (N_LINES),
        .N_POST     (N_POST)
    ) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .csync      (csync_o),
        .act        (act),
        .fetch_go   (fetch_go),
        .frame_start(frame_start)
    );

    vid_fetch #(
        .BYTES_PER_LINE(BYTES_PER_LINE),
        .BYTE_CLKS     (BYTE_CLKS),
        .ADDR_W        (ADDR_W),
        .BASE_ADDR     (BASE_ADDR)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .fetch_go   (fetch_go),
        .rd_en      (fb_rd_en),
        .rd_addr    (fb_rd_addr)
    );

    vid_shifter #(
        .DATA_W  (DATA_W),
        .PIX_CLKS(PIX_CLKS)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (fb_rd_en),
        .rd_data(fb_rd_data),
        .act    (act),
        .video  (video_o)
    );

    AST_DARK_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !csync_o |-> !video_o); // R5
    AST_FS_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R8
    AST_NO_READ_AT_FS: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> !fb_rd_en); // R7

endmodule

// File: tb/tb_pal_mono_video.sv
// Behavioural reference bench: an integer frame-offset model predicts every
// output on every clock and compares at the falling edge.
module tb_pal_mono_video;
    localparam int NL    = 6;
    localparam int HS    = 96;
    localparam int BP    = 192;
    localparam int LINE  = 1536;
    localparam int HALF  = 768;
    localparam int EQ    = 48;
    localparam int ACT0  = HS + BP;
    localparam int NB    = 52;
    localparam int BASE  = 256;
    localparam int VPRE  = 10 * HALF;
    localparam int PICE  = VPRE + NL * LINE;
    localparam int FRAME = PICE + 6 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fb_rd_en;
    logic [15:0] fb_rd_addr;
    logic [7:0]  fb_rd_data = 8'h00;
    logic        csync_o;
    logic        video_o;
    logic        frame_start;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int run_m = 0;
    int t = 0;
    int falls = 0;
    int seen0 = 0;
    logic prev_sync = 1'b1;

    always #2 clk = ~clk;

    pal_mono_video #(.N_LINES(NL), .BASE_ADDR(16'h0100)) dut (
        .clk(clk), .rst_n(rst_n), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
        .fb_rd_data(fb_rd_data), .csync_o(csync_o), .video_o(video_o),
        .frame_start(frame_start)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29) ^ (a >> 4) ^ 165);
    endfunction

    // Frame buffer model: one clock read latency.
    always @(posedge clk) if (fb_rd_en) fb_rd_data <= pat(int'(fb_rd_addr));

    // Reference time base.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin run_m <= 0; t <= 0; end
        else if (run_m == 0) begin run_m <= 1; t <= 0; end
        else t <= t + 1;
    end

    task automatic chk(string tag, int actual, int expv);
        compared++;
        if (actual != expv) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expv, $time);
        end
    endtask

    int f, p, g, ln, q, e_sync, e_vid, e_rd, rd_idx;
    string stag, vtag;

    always @(negedge clk) begin
        if (run_m == 0) begin
            chk("R9 sync in reset", int'(csync_o), 1);
            chk("R9 video in reset", int'(video_o), 0);
            chk("R9 frame_start in reset", int'(frame_start), 0);
            falls = 0; seen0 = 0; prev_sync = 1'b1;
        end else begin
            f = t % FRAME;
            e_vid = 0; e_rd = 0; rd_idx = 0;
            vtag = "R5 video dark";
            if (f < 5 * HALF) begin
                p = f % HALF; e_sync = (p >= HALF - EQ) ? 1 : 0; stag = "R2 wide sync";
            end else if (f < VPRE) begin
                p = (f - 5 * HALF) % HALF; e_sync = (p >= EQ) ? 1 : 0; stag = "R3 narrow sync";
            end else if (f < PICE) begin
                g = f - VPRE; ln = g / LINE; p = g % LINE;
                e_sync = (p >= HS) ? 1 : 0; stag = "R1 line sync";
                if (p >= ACT0) begin
                    q = p - ACT0;
                    e_vid = int'(pat(BASE + ln * NB + q / 24)[(q / 3) % 8]);
                    vtag = "R6 pixel";
                end
                if (p >= ACT0 - 2 && p < ACT0 - 2 + NB * 24 && (p - ACT0 + 2) % 24 == 0) begin
                    e_rd = 1; rd_idx = BASE + ln * NB + (p - ACT0 + 2) / 24;
                end
            end else begin
                p = (f - PICE) % HALF; e_sync = (p >= EQ) ? 1 : 0; stag = "R3 trailing narrow sync";
            end
            chk(stag, int'(csync_o), e_sync);
            chk(vtag, int'(video_o), e_vid);
            chk("R8 frame_start", int'(frame_start), (f == 0) ? 1 : 0);
            chk("R7 read request", int'(fb_rd_en), e_rd);
            if (e_rd != 0) chk("R7 read address", int'(fb_rd_addr), rd_idx);
            // R4: falling sync edges per complete frame
            if (f == 0) begin seen0 = 1; falls = 0; end
            if (prev_sync && !csync_o) falls++;
            if (f == FRAME - 1 && seen0 != 0) chk("R4 sync edges per frame", falls, 16 + NL);
            prev_sync = csync_o;
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            report();
        end
    end

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_neg(5);
        rst_n <= 1'b1;
        wait_neg(2 * FRAME + 500);
        // R9: reset in the middle of a picture line restarts the frame
        rst_n <= 1'b0;
        wait_neg(4);
        rst_n <= 1'b1;
        wait_neg(FRAME + 3000);
        report();
    end

endmodule